// File: doc/BRIEF.md
# Protected Clock Source Selector

This block picks which of six oscillators drives the system clock: three calibrated internal oscillators, an external oscillator, a low-frequency crystal oscillator and a PLL output. Each oscillator appears only as an enable output, a ready input and a clock-enable tick input; the analog circuits are not modelled. Software issues two kinds of request: a source selection carrying a 3-bit code, and a write of the full oscillator enable vector. Either may arrive at any time during normal operation.

The block guards the clock tree. It refuses a selection whose target is disabled, not ready or not a valid code. It refuses to turn off the oscillator that is the active source. A refusal is reported by a one-cycle pulse. An accepted selection stays pending until the active source's next clock-enable tick. The active source then changes directly after that tick, so the system clock enable only ever carries whole ticks of one source. The target is checked again at that point. A per-oscillator status flag reports which oscillators are enabled and ready.

Top module: `clk_src_guard`

## Requirements
- R1: After reset the active source code is 0, only oscillator 0 is enabled, and no rejection pulse is present.
- R2: The selection field is 3 bits wide. Codes 0 to 5 name internal A, internal B, internal C, external, low-frequency crystal and PLL. Codes 6 and 7 are always refused.
- R3: A selection is accepted only if its target is enabled and its ready input is high. Otherwise it is refused and the active source does not change.
- R4: An accepted selection takes effect at the first clock edge where the tick input of the active source is high. The new code is visible from the next cycle. Ticks of other oscillators do not commit it.
- R5: The system clock enable output equals the tick input of the active source.
- R6: An enable write applies its vector to every bit except the active source's bit, which stays set. If the written vector clears that bit, the write is flagged as refused.
- R7: At the commit edge the pending target is checked again. If it is no longer enabled and ready, the switch is dropped, the active source stays, and a refusal is flagged.
- R8: Every refused request, and every dropped switch, raises the rejection output for the single cycle after the edge where it occurred.
- R9: The status flag of each oscillator is high exactly when that oscillator is enabled and its ready input is high.
- R10: A later accepted selection replaces a pending one. An accepted selection of the source that is about to be active cancels any pending switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_req_i | input | 1 | Source selection request strobe |
| sel_code_i | input | 3 | Requested source code |
| en_wr_i | input | 1 | Enable vector write strobe |
| en_wdata_i | input | 6 | New oscillator enable vector |
| osc_rdy_i | input | 6 | Oscillator ready inputs (synchronous) |
| osc_tick_i | input | 6 | Per-oscillator clock-enable ticks |
| act_src_o | output | 3 | Code of the active source |
| osc_en_o | output | 6 | Oscillator enables |
| osc_ready_o | output | 6 | Per-oscillator status flags (enabled and ready) |
| sys_ce_o | output | 1 | System clock enable |
| reject_o | output | 1 | One-cycle rejection pulse |

## Verification
The main sweep tries all eight selection codes against all four combinations of target enable and target ready. This separates the invalid-code, disabled-target and unready-target refusals from the accepted switches, and from the self-selection of the active source. Each case also writes an enable vector first, so clearing the active bit is told apart from clearing any other bit. Directed sequences cover the remaining cases: ticks of non-active sources, a pending selection replaced or cancelled, the full-vector disable of the active source, and a target that loses its ready input between acceptance and the commit edge.

// File: rtl/clk_src_guard_pkg.sv
// Shared constants and source codes for the protected clock source selector.
// Assumes at most eight oscillators, so the code fits in three bits.
package clk_src_guard_pkg;

    localparam int unsigned CSG_SRC_COUNT = 6;
    localparam int unsigned CSG_CODE_W    = 3;

    typedef enum logic [CSG_CODE_W-1:0] {
        SRC_INT_A   = 3'd0,
        SRC_INT_B   = 3'd1,
        SRC_INT_C   = 3'd2,
        SRC_EXT     = 3'd3,
        SRC_LF_XTAL = 3'd4,
        SRC_PLL     = 3'd5
    } src_code_e;

endpackage

// File: rtl/csg_req_check.sv
// Selection request screening: classifies a request as acceptable or refused.
// Assumes usable_i is already the AND of enables and ready inputs.
module csg_req_check #(
    parameter int unsigned N_SRC = 6,
    parameter int unsigned SEL_W = 3
) (
    input  logic             req_i,
    input  logic [SEL_W-1:0] code_i,
    input  logic [N_SRC-1:0] usable_i,
    output logic             accept_o,
    output logic             refuse_o
);
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(N_SRC - 1);

    logic in_range;
    logic target_ok;

    // Decide whether the named oscillator exists and can drive the clock.
    always_comb begin
        in_range  = (code_i <= LAST_CODE);
        target_ok = in_range && usable_i[code_i];
        accept_o  = req_i && target_ok;
        refuse_o  = req_i && !target_ok;
    end

endmodule

// File: rtl/csg_enable_reg.sv
// Oscillator enable register with protection of the active source's bit.
// Assumes keep_idx_i names the source that will be active after this edge.
module csg_enable_reg #(
    parameter int unsigned N_SRC   = 6,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned DEF_SRC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [SEL_W-1:0] keep_idx_i,
    output logic [N_SRC-1:0] en_o,
    output logic             refuse_o
);
    localparam logic [N_SRC-1:0] RST_EN = N_SRC'(1) << DEF_SRC;

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] keep_mask;

    // Build the protected-bit mask and flag writes that try to clear it.
    always_comb begin
        keep_mask = N_SRC'(1) << keep_idx_i;
        refuse_o  = wr_i && ((wdata_i & keep_mask) != keep_mask);
    end

    // Store the written vector with the protected bit forced on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= RST_EN;
        end else if (wr_i) begin
            en_q <= wdata_i | keep_mask;
        end
    end

    assign en_o = en_q;

    // R6: after any write, the protected source is still enabled.
    a_r6_keep_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> en_q[$past(keep_idx_i)]);

endmodule

// File: rtl/csg_switch_ctrl.sv
// Pending-switch and active-source control. A switch commits only on the
// active source's tick, so the system clock enable never splits a tick.
// Assumes ticks and ready inputs are already synchronous to clk.
module csg_switch_ctrl #(
    parameter int unsigned N_SRC   = 6,
    parameter int unsigned SEL_W   = 3,
    parameter int unsigned DEF_SRC = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [SEL_W-1:0] code_i,
    input  logic [N_SRC-1:0] usable_i,
    input  logic [N_SRC-1:0] tick_i,
    output logic [SEL_W-1:0] act_o,
    output logic [SEL_W-1:0] act_nxt_o,
    output logic             commit_fail_o,
    output logic             sys_ce_o
);
    localparam logic [SEL_W-1:0] DEF_CODE  = SEL_W'(DEF_SRC);
    localparam logic [SEL_W-1:0] LAST_CODE = SEL_W'(N_SRC - 1);

    logic [SEL_W-1:0] act_q;
    logic [SEL_W-1:0] pend_q;
    logic             pend_vld_q;
    logic             at_edge;
    logic             commit_go;
    logic [SEL_W-1:0] act_nxt;

    // Detect the commit edge and recheck the pending target there.
    always_comb begin
        at_edge       = pend_vld_q && tick_i[act_q];
        commit_go     = at_edge && usable_i[pend_q];
        commit_fail_o = at_edge && !usable_i[pend_q];
        act_nxt       = commit_go ? pend_q : act_q;
    end

    // Hold the active source and the single pending switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q      <= DEF_CODE;
            pend_q     <= DEF_CODE;
            pend_vld_q <= 1'b0;
        end else begin
            act_q <= act_nxt;
            if (accept_i && (code_i == act_nxt)) begin
                pend_vld_q <= 1'b0;
            end else if (accept_i) begin
                pend_q     <= code_i;
                pend_vld_q <= 1'b1;
            end else if (at_edge) begin
                pend_vld_q <= 1'b0;
            end
        end
    end

    assign act_o     = act_q;
    assign act_nxt_o = act_nxt;
    assign sys_ce_o  = tick_i[act_q];

    // Checker state: which sources were usable one cycle ago.
    logic [N_SRC-1:0] usable_q;
    always_ff @(posedge clk) begin
        if (!rst_n) usable_q <= '0;
        else        usable_q <= usable_i;
    end

    // R4: without a tick of the active source the selection cannot move.
    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i[act_q] |=> $stable(act_q));

    // R3 / R7: a newly active source was enabled and ready at the commit edge.
    a_r3_new_source_usable: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> usable_q[act_q]);

    // R2: the active code always names an existing oscillator.
    a_r2_code_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        act_q <= LAST_CODE);

endmodule

// File: rtl/clk_src_guard.sv
// Protected clock source selector top. Screens selection and enable
// requests, holds the enable vector, commits switches on tick boundaries
// and reports refusals with a registered one-cycle pulse.
// Assumes all inputs are synchronous to clk.
module clk_src_guard
    import clk_src_guard_pkg::*;
#(
    parameter int unsigned N_SRC   = CSG_SRC_COUNT,
    parameter int unsigned SEL_W   = CSG_CODE_W,
    parameter int unsigned DEF_SRC = SRC_INT_A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_req_i,
    input  logic [SEL_W-1:0] sel_code_i,
    input  logic             en_wr_i,
    input  logic [N_SRC-1:0] en_wdata_i,
    input  logic [N_SRC-1:0] osc_rdy_i,
    input  logic [N_SRC-1:0] osc_tick_i,
    output logic [SEL_W-1:0] act_src_o,
    output logic [N_SRC-1:0] osc_en_o,
    output logic [N_SRC-1:0] osc_ready_o,
    output logic             sys_ce_o,
    output logic             reject_o
);
    logic [N_SRC-1:0] en_w;
    logic [N_SRC-1:0] usable_w;
    logic             sel_accept;
    logic             sel_refuse;
    logic             en_refuse;
    logic             commit_fail;
    logic [SEL_W-1:0] act_w;
    logic [SEL_W-1:0] act_nxt_w;
    logic             reject_q;

    assign usable_w    = en_w & osc_rdy_i;
    assign osc_ready_o = usable_w;

    csg_req_check #(.N_SRC(N_SRC), .SEL_W(SEL_W)) chk_i (
        .req_i    (sel_req_i),
        .code_i   (sel_code_i),
        .usable_i (usable_w),
        .accept_o (sel_accept),
        .refuse_o (sel_refuse)
    );

    csg_switch_ctrl #(.N_SRC(N_SRC), .SEL_W(SEL_W), .DEF_SRC(DEF_SRC)) sw_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (sel_accept),
        .code_i        (sel_code_i),
        .usable_i      (usable_w),
        .tick_i        (osc_tick_i),
        .act_o         (act_w),
        .act_nxt_o     (act_nxt_w),
        .commit_fail_o (commit_fail),
        .sys_ce_o      (sys_ce_o)
    );

    csg_enable_reg #(.N_SRC(N_SRC), .SEL_W(SEL_W), .DEF_SRC(DEF_SRC)) en_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (en_wr_i),
        .wdata_i    (en_wdata_i),
        .keep_idx_i (act_nxt_w),
        .en_o       (en_w),
        .refuse_o   (en_refuse)
    );

    // Merge all refusals of this cycle into one registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) reject_q <= 1'b0;
        else        reject_q <= sel_refuse | en_refuse | commit_fail;
    end

    assign act_src_o = act_w;
    assign osc_en_o  = en_w;
    assign reject_o  = reject_q;

    // R6: the oscillator driving the system clock is never disabled.
    a_r6_active_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en_o[act_src_o]);

    // R8: an invalid code is always followed by a rejection pulse.
    a_r8_bad_code_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_req_i && (sel_code_i > SEL_W'(N_SRC - 1))) |=> reject_o);

endmodule

// File: tb/clk_src_guard_tb_top.sv
module clk_src_guard_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_req_i = 1'b0;
    logic [2:0] sel_code_i = '0;
    logic       en_wr_i = 1'b0;
    logic [5:0] en_wdata_i = '0;
    logic [5:0] osc_rdy_i = '1;
    logic [5:0] osc_tick_i = '0;
    logic [2:0] act_src_o;
    logic [5:0] osc_en_o;
    logic [5:0] osc_ready_o;
    logic       sys_ce_o;
    logic       reject_o;

    int n_checks = 0;
    int n_errors = 0;
    int exp_act  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_src_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .sel_req_i(sel_req_i), .sel_code_i(sel_code_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
        .osc_rdy_i(osc_rdy_i), .osc_tick_i(osc_tick_i),
        .act_src_o(act_src_o), .osc_en_o(osc_en_o),
        .osc_ready_o(osc_ready_o), .sys_ce_o(sys_ce_o),
        .reject_o(reject_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual !== expected) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic pulse_sel(input int code);
        @(negedge clk);
        sel_req_i  = 1'b1;
        sel_code_i = code[2:0];
        @(negedge clk);
        sel_req_i  = 1'b0;
    endtask

    task automatic write_en(input logic [5:0] mask);
        @(negedge clk);
        en_wr_i    = 1'b1;
        en_wdata_i = mask;
        @(negedge clk);
        en_wr_i    = 1'b0;
    endtask

    task automatic tick_src(input int idx, output logic ce_seen);
        @(negedge clk);
        osc_tick_i = 6'(1) << idx;
        #1 ce_seen = sys_ce_o;
        @(negedge clk);
        osc_tick_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic ce;
        logic [5:0] mask;
        logic [5:0] en_exp;
        bit ok;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 active", act_src_o, 0);
        check("R1 enables", osc_en_o, 6'b000001);
        check("R1 reject", reject_o, 0);

        // Sweep: every code against target enable and ready combinations.
        for (int c = 0; c < 8; c++) begin
            for (int e = 0; e < 2; e++) begin
                for (int r = 0; r < 2; r++) begin
                    // restore: everything on, source 0 active
                    osc_rdy_i = '1;
                    write_en(6'b111111);
                    pulse_sel(0);
                    tick_src(exp_act, ce);
                    check("R5 tick passes", ce, 1);
                    exp_act = 0;
                    check("R4 back to 0", act_src_o, 0);

                    mask = 6'b111111;
                    if (c < NS) mask[c] = e[0];
                    write_en(mask);
                    en_exp = mask | 6'b000001;
                    check("R6 write refusal", reject_o, (c == 0 && e == 0) ? 1 : 0);
                    check("R6 enables", osc_en_o, en_exp);

                    @(negedge clk);
                    if (c < NS) osc_rdy_i[c] = r[0];
                    #1 check("R9 status", osc_ready_o, en_exp & osc_rdy_i);

                    ok = (c < NS) && en_exp[c % NS] && (r == 1);
                    pulse_sel(c);
                    check(c >= NS ? "R2 bad code" : "R3 select screen", reject_o, ok ? 0 : 1);
                    check("R4 no change before tick", act_src_o, 0);

                    tick_src(0, ce);
                    check("R5 tick passes", ce, 1);
                    exp_act = ok ? c : 0;
                    check("R4 commit on tick", act_src_o, exp_act);
                    check("R8 no stray reject", reject_o, 0);
                end
            end
        end

        // Directed: replacement and foreign ticks (R10, R4)
        osc_rdy_i = '1;
        write_en(6'b111111);
        pulse_sel(0);
        tick_src(exp_act, ce);
        exp_act = 0;
        pulse_sel(2);
        pulse_sel(4);
        tick_src(1, ce);
        check("R5 foreign tick hidden", ce, 0);
        check("R4 foreign tick no commit", act_src_o, 0);
        tick_src(0, ce);
        check("R10 replaced pending", act_src_o, 4);
        exp_act = 4;

        // R10: selecting the active source cancels a pending switch
        pulse_sel(1);
        pulse_sel(4);
        check("R10 self select accepted", reject_o, 0);
        tick_src(4, ce);
        check("R10 cancel", act_src_o, 4);

        // R6: disabling everything keeps the active source on
        write_en(6'b000000);
        check("R6 refused", reject_o, 1);
        check("R6 active kept", osc_en_o, 6'b010000);

        // R7: target loses ready before commit
        write_en(6'b111111);
        pulse_sel(3);
        check("R7 accepted", reject_o, 0);
        @(negedge clk);
        osc_rdy_i[3] = 1'b0;
        tick_src(4, ce);
        check("R7 commit dropped", act_src_o, 4);
        check("R7 refusal flagged", reject_o, 1);
        @(negedge clk);
        check("R8 single cycle", reject_o, 0);
        osc_rdy_i = '1;
        tick_src(4, ce);
        check("R7 pending gone", act_src_o, 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule